// File: doc/BRIEF.md
# Pipelined Converter Digital Correction Backend

This block is the digital half of a 12-bit pipelined analog-to-digital converter. The analog side has ten stages. A 3-bit front stage comes first, then eight 1.5-bit middle stages, then a 4-bit flash at the end. Each stage hands over its decision code on a staggered schedule. The backend delays every code so that all codes of one sample meet on the same cycle. It then adds the codes with one bit of overlap between neighbouring stages, so that comparator offsets in any stage are absorbed by the stages after it.

The corrected sum is clamped to the 12-bit range, and an over-range flag is raised whenever clamping happens. The word is then coded as offset binary or as two's complement and placed in an output register. An active-low enable can release the data bus and the flag to high impedance without disturbing the pipeline.

Top module: `adc_corr_backend`

## Requirements
- R1: The corrected sum is S = 512·f + 256 + Σ(k=1..8) (m_k − 1)·2^(9−k) + (c − 8), where f is the front code (0..7), m_k is middle stage k's code (0, 1 or 2, stage 1 most significant), and c is the flash code (0..15). When 0 ≤ S ≤ 4095, the offset-binary output equals S.
- R2: The code for stage i (0 = front, 1..8 = middle, 9 = flash) is presented floor(i/4) cycles after the front code of the same sample. The output word for that sample appears on the fifth rising edge after the edge that registered its front code.
- R3: Decisions made with comparator thresholds moved by up to a quarter of the stage weight still reproduce the exact target value.
- R4: When S > 4095, the offset-binary output is all ones and the over-range flag is 1.
- R5: When S < 0, the offset-binary output is all zeros and the over-range flag is 1.
- R6: Three in-range values produce these offset-binary outputs with the flag at 0: mid-scale (2048) gives 0x800, full scale minus one LSB (4095) gives 0xFFF, and zero gives 0x000.
- R7: With twos_i = 1, the output is the offset-binary word with only bit 11 inverted. The output register samples twos_i on the same edge that loads the word. With twos_i = 0 the output is offset binary.
- R8: The over-range flag has the same latency as the data word and updates on the same edge.
- R9: oe_ni = 1 places data_o and ovr_o in high impedance without a clock edge. oe_ni = 0 drives them.
- R10: While rst_ni is low, data_o and ovr_o are 0 (with oe_ni low).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Conversion clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| front_code_i | input | 3 | Front stage decision, 0..7 |
| mid_code_i | input | 16 | Middle stage decisions, stage k in bits [2k−1:2k−2], each 0..2 |
| flash_code_i | input | 4 | Back-end flash decision, 0..15 |
| twos_i | input | 1 | 1 selects two's complement, 0 selects offset binary |
| oe_ni | input | 1 | Active-low output enable |
| data_o | output | 12 | Corrected output word, tri-stateable |
| ovr_o | output | 1 | Over-range flag, tri-stateable |

## Verification
Every target code from 0 to 4095 is driven twice. The first pass uses ideal decisions, which confirms the weights and the alignment delays. The second pass uses decisions with random threshold offsets of a quarter of the stage weight; a design that drops the stage overlap fails here while still passing the ideal sweep. Targets above and below full scale separate the two clamp directions and the flag. Mid-scale and rail values, repeated under both codings, show that only the MSB is inverted. Disabled cycles are given a target of zero, so a pulled-up bus can only read back if the drivers are truly released.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;

  typedef enum logic {
    CODE_OFFSET = 1'b0,
    CODE_TWOS   = 1'b1
  } out_code_e;

  function automatic int arrive_cyc(int stage, int per);
    return stage / per;
  endfunction

  function automatic int max_i(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_stage_delay.sv
module adc_stage_delay #(
  parameter int W     = 4,
  parameter int DEPTH = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] sh_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) sh_q[i] <= '0;
    end else begin
      sh_q[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) sh_q[i] <= sh_q[i-1];
    end
  end

  assign q_o = sh_q[DEPTH-1];

endmodule

// File: rtl/adc_corr_sum.sv
module adc_corr_sum #(
  parameter int N_MID   = 8,
  parameter int FRONT_W = 3,
  parameter int FLASH_W = 4,
  parameter int CODE_W  = 4,
  parameter int OUT_W   = N_MID + 1 + FRONT_W,
  localparam int N_STG  = N_MID + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i [N_STG],
  output logic [OUT_W-1:0]  word_o,
  output logic              ovr_o
);

  localparam int SUM_W  = OUT_W + 2;
  localparam int HALF   = N_MID / 2;
  localparam int BIAS   = 2 ** N_MID;
  localparam int FL_MID = 2 ** (FLASH_W - 1);
  localparam logic [SUM_W-1:0] MAX_V = SUM_W'(2 ** OUT_W - 1);

  logic [SUM_W-1:0] front_d, back_d, front_q, back_q, total;
  logic             neg, high;
  logic [OUT_W-1:0] word_d;

  // front half: front stage plus upper middle stages; back half: the rest plus flash
  always_comb begin
    front_d = SUM_W'(code_i[0]) << (N_MID + 1);
    front_d = front_d + SUM_W'(BIAS);
    for (int k = 1; k <= HALF; k++)
      front_d = front_d + ((SUM_W'(code_i[k]) - SUM_W'(1)) << (N_MID + 1 - k));
    back_d = SUM_W'(code_i[N_STG-1]) - SUM_W'(FL_MID);
    for (int k = HALF + 1; k <= N_MID; k++)
      back_d = back_d + ((SUM_W'(code_i[k]) - SUM_W'(1)) << (N_MID + 1 - k));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      front_q <= '0;
      back_q  <= '0;
    end else begin
      front_q <= front_d;
      back_q  <= back_d;
    end
  end

  assign total = front_q + back_q;
  assign neg   = total[SUM_W-1];
  assign high  = !neg && (total > MAX_V);

  always_comb begin
    if (neg)       word_d = '0;
    else if (high) word_d = '1;
    else           word_d = total[OUT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o <= '0;
      ovr_o  <= 1'b0;
    end else begin
      word_o <= word_d;
      ovr_o  <= neg | high;
    end
  end

endmodule

// File: rtl/adc_out_stage.sv
module adc_out_stage
  import adc_corr_pkg::*;
#(
  parameter int OUT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OUT_W-1:0] word_i,
  input  logic             ovr_i,
  input  out_code_e        code_sel_i,
  input  logic             oe_ni,
  output logic [OUT_W-1:0] data_o,
  output logic             ovr_o
);

  logic [OUT_W-1:0] data_q;
  logic             ovr_q;
  logic [OUT_W-1:0] msb_flip;

  assign msb_flip = {(code_sel_i == CODE_TWOS), {(OUT_W-1){1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      data_q <= word_i ^ msb_flip;
      ovr_q  <= ovr_i;
    end
  end

  assign data_o = oe_ni ? {OUT_W{1'bz}} : data_q;
  assign ovr_o  = oe_ni ? 1'bz : ovr_q;

endmodule

// File: rtl/adc_corr_backend.sv
module adc_corr_backend
  import adc_corr_pkg::*;
#(
  parameter int N_MID       = 8,
  parameter int FRONT_W     = 3,
  parameter int FLASH_W     = 4,
  parameter int STG_PER_CYC = 4,
  localparam int OUT_W      = N_MID + 1 + FRONT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FRONT_W-1:0] front_code_i,
  input  logic [2*N_MID-1:0] mid_code_i,
  input  logic [FLASH_W-1:0] flash_code_i,
  input  logic               twos_i,
  input  logic               oe_ni,
  output logic [OUT_W-1:0]   data_o,
  output logic               ovr_o
);

  localparam int N_STG  = N_MID + 2;
  localparam int CODE_W = max_i(max_i(FRONT_W, FLASH_W), 2);
  localparam int A_MAX  = (N_STG - 1) / STG_PER_CYC;
  localparam int LAT    = A_MAX + 3;

  logic [CODE_W-1:0] raw_code [N_STG];
  logic [CODE_W-1:0] al_code  [N_STG];
  logic [OUT_W-1:0]  sum_word;
  logic              sum_ovr;

  always_comb begin
    raw_code[0] = CODE_W'(front_code_i);
    for (int k = 1; k <= N_MID; k++)
      raw_code[k] = CODE_W'(mid_code_i[2*k-2 +: 2]);
    raw_code[N_STG-1] = CODE_W'(flash_code_i);
  end

  // early stages wait longer so every code of a sample lands on edge A_MAX
  for (genvar g = 0; g < N_STG; g++) begin : g_align
    adc_stage_delay #(
      .W     (CODE_W),
      .DEPTH (1 + A_MAX - arrive_cyc(g, STG_PER_CYC))
    ) u_dly (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw_code[g]),
      .q_o   (al_code[g])
    );
  end

  adc_corr_sum #(
    .N_MID  (N_MID),
    .FRONT_W(FRONT_W),
    .FLASH_W(FLASH_W),
    .CODE_W (CODE_W),
    .OUT_W  (OUT_W)
  ) u_sum (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .code_i(al_code),
    .word_o(sum_word),
    .ovr_o (sum_ovr)
  );

  adc_out_stage #(
    .OUT_W(OUT_W)
  ) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .word_i    (sum_word),
    .ovr_i     (sum_ovr),
    .code_sel_i(out_code_e'(twos_i)),
    .oe_ni     (oe_ni),
    .data_o    (data_o),
    .ovr_o     (ovr_o)
  );

endmodule

// File: rtl/adc_corr_backend_chk.sv
module adc_corr_backend_chk #(
  parameter int OUT_W   = 12,
  parameter int CODE_W  = 4,
  parameter int FRONT_W = 3,
  parameter int FLASH_W = 4,
  parameter int A_MAX   = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [FRONT_W-1:0] front_code_i,
  input logic [FLASH_W-1:0] flash_code_i,
  input logic [CODE_W-1:0]  al_first,
  input logic [CODE_W-1:0]  al_last,
  input logic [OUT_W-1:0]   sum_word,
  input logic               sum_ovr,
  input logic               twos_i,
  input logic               oe_ni,
  input logic [OUT_W-1:0]   data_o,
  input logic               ovr_o
);

  localparam int D_FRONT = A_MAX + 1;

  logic [7:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cyc_q <= '0;
    else if (cyc_q != 8'hFF)  cyc_q <= cyc_q + 8'd1;
  end

  a_r2_align_front: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 8'(D_FRONT)) |-> (al_first == CODE_W'($past(front_code_i, D_FRONT))));

  a_r2_align_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 8'd1) |-> (al_last == CODE_W'($past(flash_code_i))));

  // R5 shares this rail check
  a_r4_clamp_rail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_ovr |-> (sum_word == '0 || sum_word == '1));

  a_r7_coding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 8'd1 && !oe_ni) |->
      (data_o == ($past(sum_word) ^ {$past(twos_i), {(OUT_W-1){1'b0}}})));

  a_r8_ovr_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 8'd1 && !oe_ni) |-> (ovr_o == $past(sum_ovr)));

endmodule

bind adc_corr_backend adc_corr_backend_chk #(
  .OUT_W  (OUT_W),
  .CODE_W (CODE_W),
  .FRONT_W(FRONT_W),
  .FLASH_W(FLASH_W),
  .A_MAX  (A_MAX)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .front_code_i(front_code_i),
  .flash_code_i(flash_code_i),
  .al_first    (al_code[0]),
  .al_last     (al_code[N_STG-1]),
  .sum_word    (sum_word),
  .sum_ovr     (sum_ovr),
  .twos_i      (twos_i),
  .oe_ni       (oe_ni),
  .data_o      (data_o),
  .ovr_o       (ovr_o)
);

// File: tb/tb_adc_corr_backend.sv
`timescale 1ns/1ps
module tb_adc_corr_backend;

  localparam int NS = 4096 + 4096 + 128 + 12 + 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  front_code;
  logic [15:0] mid_code;
  logic [3:0]  flash_code;
  logic        twos;
  logic        oe_n;
  tri1  [11:0] data_w;
  tri1         ovr_w;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;

  int          tgt  [NS];
  int          ssum [NS];
  bit          tw   [NS];
  bit          oen  [NS];
  logic [2:0]  a0   [NS];
  logic [15:0] am   [NS];
  logic [3:0]  af   [NS];
  string       tag  [NS];

  always #2.5 clk = ~clk;

  adc_corr_backend dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .front_code_i(front_code),
    .mid_code_i  (mid_code),
    .flash_code_i(flash_code),
    .twos_i      (twos),
    .oe_ni       (oe_n),
    .data_o      (data_w),
    .ovr_o       (ovr_w)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int pick_off(int q, bit en);
    int m;
    if (!en) return 0;
    m = int'($urandom_range(2)) - 1;
    return m * q;
  endfunction

  // ideal or offset stage decisions for target t (R1, R3)
  task automatic gen(int idx, int t, bit offs, bit two, bit dis, string tg);
    int r, q, c0, c, w, d, cf, s;
    q  = t + pick_off(128, offs);
    c0 = (q < 0) ? 0 : ((q / 512 > 7) ? 7 : q / 512);
    r  = t - 512 * c0 - 256;
    s  = 512 * c0 + 256;
    am[idx] = '0;
    for (int k = 1; k <= 8; k++) begin
      w = 256 >> (k - 1);
      d = pick_off(w / 4, offs);
      if (r >= w / 2 + d)       c = 2;
      else if (r < -w / 2 + d)  c = 0;
      else                      c = 1;
      r = r - (c - 1) * w;
      s = s + (c - 1) * w;
      am[idx][2*k-2 +: 2] = 2'(c);
    end
    cf = r + 8;
    if (cf < 0)  cf = 0;
    if (cf > 15) cf = 15;
    s = s + cf - 8;
    a0[idx]   = 3'(c0);
    af[idx]   = 4'(cf);
    tgt[idx]  = t;
    ssum[idx] = s;
    tw[idx]   = two;
    oen[idx]  = dis;
    tag[idx]  = tg;
  endtask

  task automatic check_sample(int s);
    int exp_word, exp_data;
    bit exp_ovr;
    if (oen[s]) begin
      // R9: released bus reads the pull-up value; target 0 would drive zeros
      chk(data_w == 12'hFFF, "R9", "data released", int'(data_w), 'hFFF);
      chk(ovr_w == 1'b1, "R9", "flag released", int'(ovr_w), 1);
      return;
    end
    if (tgt[s] >= 0 && tgt[s] <= 4095) begin
      exp_word = tgt[s];
      exp_ovr  = 1'b0;
    end else if (ssum[s] > 4095) begin
      exp_word = 'hFFF;
      exp_ovr  = 1'b1;
    end else if (ssum[s] < 0) begin
      exp_word = 0;
      exp_ovr  = 1'b1;
    end else begin
      exp_word = ssum[s];
      exp_ovr  = 1'b0;
    end
    exp_data = tw[s] ? (exp_word ^ 'h800) : exp_word;
    chk(data_w == 12'(exp_data), tag[s], "data", int'(data_w), exp_data);
    chk(ovr_w == exp_ovr, "R8", "over-range flag", int'(ovr_w), int'(exp_ovr));
  endtask

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int idx;
    idx = 0;
    for (int t = 0; t < 4096; t++) begin gen(idx, t, 1'b0, 1'b0, 1'b0, "R1"); idx++; end
    for (int t = 0; t < 4096; t++) begin
      gen(idx, t, 1'b1, 1'($urandom_range(1)), 1'b0, ((t & 1) != 0) ? "R3" : "R7");
      idx++;
    end
    for (int i = 0; i < 64; i++) begin
      gen(idx, 4096 + int'($urandom_range(600)), 1'b1, 1'($urandom_range(1)), 1'b0, "R4"); idx++;
    end
    for (int i = 0; i < 64; i++) begin
      gen(idx, -1 - int'($urandom_range(600)), 1'b1, 1'($urandom_range(1)), 1'b0, "R5"); idx++;
    end
    for (int p = 0; p < 2; p++) begin
      gen(idx, 2048, 1'b0, 1'(p), 1'b0, "R6"); idx++;
      gen(idx, 4095, 1'b0, 1'(p), 1'b0, "R6"); idx++;
      gen(idx, 0,    1'b0, 1'(p), 1'b0, "R6"); idx++;
      gen(idx, 4096, 1'b0, 1'(p), 1'b0, "R4"); idx++;
      gen(idx, -1,   1'b0, 1'(p), 1'b0, "R5"); idx++;
      gen(idx, 2047, 1'b0, 1'(p), 1'b0, "R7"); idx++;
    end
    for (int i = 0; i < 16; i++) begin
      gen(idx, 0, 1'b0, 1'b0, 1'b1, "R9"); idx++;
      gen(idx, int'($urandom_range(4095)), 1'b0, 1'b0, 1'b0, "R2"); idx++;
    end

    rst_n = 1'b0; front_code = '0; mid_code = '0; flash_code = '0; twos = 1'b0; oe_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(data_w == 12'h000, "R10", "reset data", int'(data_w), 0);
    chk(ovr_w == 1'b0, "R10", "reset flag", int'(ovr_w), 0);
    rst_n = 1'b1;

    // R2: stage groups offset by 0, 1, 2 cycles; sample s checked after edge s+5
    for (int t = 0; t < NS + 7; t++) begin
      int s0, s1, s2, sc, st;
      @(negedge clk);
      sc = t - 6;
      if (sc >= 0 && sc < NS) begin
        oe_n = oen[sc];
        #1;
        check_sample(sc);
      end else begin
        oe_n = 1'b0;
      end
      s0 = t; s1 = t - 1; s2 = t - 2; st = t - 5;
      front_code = (s0 < NS) ? a0[s0] : '0;
      mid_code[5:0]   = (s0 < NS) ? am[s0][5:0] : '0;
      mid_code[13:6]  = (s1 >= 0 && s1 < NS) ? am[s1][13:6] : '0;
      mid_code[15:14] = (s2 >= 0 && s2 < NS) ? am[s2][15:14] : '0;
      flash_code      = (s2 >= 0 && s2 < NS) ? af[s2] : 4'd8;
      twos = (st >= 0 && st < NS) ? tw[st] : 1'b0;
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule